// File: doc/BRIEF.md
# Memory-Mapped Event Timer with Compare, Capture and Waveform Output

This block is a general-purpose timer on a simple synchronous register bus. The bus has separate read and write strobes, an 8-bit byte address and 32-bit data. A free-running up-counter advances on a tick strobe. Counting can be gated by a power-of-two prescaler. When the counter wraps, it either reloads from a load register or stops. Software can also force a reload through a trigger register.

Two comparison paths watch the counter. A match register raises a flag when the counter steps onto its value. An input capture latches the counter on selected edges of an external pin. Overflow and match events can drive a waveform output, which either toggles or emits a one-cycle pulse around a programmable idle level. Three event flags can be masked onto a single interrupt line.

Writes that reach the counting logic can be posted: they commit a fixed number of cycles after the bus write, and a pending register shows which write is still in flight. A soft reset clears the timer state over a few cycles. A status bit reports when that reset is done.

Top module: `gpt_timer`

## Requirements
- R1: After reset, the registers read as follows: control (0x24) 0, counter (0x28) 0, write-pending (0x34) 0 and interface control (0x40) 0. System status (0x14) reads 1. `irq_o` and `pwm_o` are low.
- R2: Interface control bit 2 selects posted mode. In posted mode, a write to control, counter, load (0x2C), trigger (0x30) or match (0x38) commits SYNC_LAT cycles after the write cycle. Until it commits, 0x34 shows a bit for the register written: bit 0 control, bit 1 counter, bit 2 load, bit 3 trigger, bit 4 match. In non-posted mode, such a write commits at the write edge and 0x34 stays 0. A write to 0x40 drops any staged write.
- R3: While control bit 0 (start) is set, the counter advances by one on each cycle with `tick_i` high. While start is clear, the counter holds.
- R4: When control bit 5 is set, the counter advances once every 2^(v+1) ticks, where v is control bits 4:2.
- R5: Any write to 0x30 copies the load register into the counter, whatever the data written. 0x30 reads as 0.
- R6: The counter wraps from all ones and sets status bit 1 (overflow) at 0x18. If control bit 1 is set, the counter then takes the load value and keeps running. If bit 1 is clear, the counter goes to 0 and start clears.
- R7: When control bit 6 is set and the counter steps onto the match register value, status bit 0 is set. When bit 6 is clear, no match flag is raised.
- R8: `irq_o` is high whenever any status bit at 0x18 is set together with the same bit of the enable register at 0x1C. Writing 1 to a bit of 0x18 clears that bit.
- R9: Control bits 9:8 select the capture edge on `cap_i`: 01 rising, 10 falling, 11 both, 00 off. On a selected edge, the counter is copied into 0x3C and status bit 2 is set.
- R10: With control bit 13 set, only every second selected edge captures. The edge parity restarts whenever capture is off.
- R11: Control bits 11:10 pick the waveform event: 01 overflow, 10 overflow or match, 11 match, 00 none. Control bit 12 chooses toggle (1) or a one-cycle pulse (0). Control bit 7 is the idle level that the output departs from. With control bit 14 set, `pwm_o` simply follows bit 7.
- R12: Writing 0x40 with bit 1 set starts a soft reset. System status bit 0 reads 0 for RST_CYC cycles and then returns to 1. Control, counter, load, match, enable, status and capture are cleared. The posted-mode bit takes bit 2 of the written value.
- R13: The counter at 0x28 can be written directly and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid while the read strobe is high, 0 otherwise |
| tick_i | input | 1 | Counting tick strobe |
| cap_i | input | 1 | Asynchronous capture input |
| pwm_o | output | 1 | Event waveform output |
| irq_o | output | 1 | Masked interrupt |

## Verification
The bench uses the defaults: a 32-bit counter, SYNC_LAT of 2 and RST_CYC of 4. With a latency of 2, a posted write is still visible as pending on the first read after it. The full 32-bit width means overflow is reached by writing values just below all ones, so reload, stop-on-wrap and the waveform events can all be exercised in a few ticks. A table of prescaler settings checks tick counts that fall both on and between advance boundaries.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam logic [7:0] A_SYSST = 8'h14;
  localparam logic [7:0] A_ISTAT = 8'h18;
  localparam logic [7:0] A_IEN   = 8'h1C;
  localparam logic [7:0] A_CTRL  = 8'h24;
  localparam logic [7:0] A_CNT   = 8'h28;
  localparam logic [7:0] A_LOAD  = 8'h2C;
  localparam logic [7:0] A_TRIG  = 8'h30;
  localparam logic [7:0] A_PEND  = 8'h34;
  localparam logic [7:0] A_MATCH = 8'h38;
  localparam logic [7:0] A_CAPT  = 8'h3C;
  localparam logic [7:0] A_IFC   = 8'h40;

  localparam logic [31:0] CTRL_MASK = 32'h0000_7FFF;

  typedef struct packed {
    logic [16:0] rsvd;
    logic        gpo;
    logic        capt2;
    logic        tgl;
    logic [1:0]  trg;
    logic [1:0]  edge_sel;
    logic        def_lvl;
    logic        cmp_en;
    logic        pre_en;
    logic [2:0]  ptv;
    logic        ar;
    logic        start;
  } ctrl_t;

  function automatic logic is_tdom(input logic [7:0] a);
    return (a == A_CTRL) || (a == A_CNT) || (a == A_LOAD) || (a == A_TRIG) || (a == A_MATCH);
  endfunction

  function automatic logic [4:0] pend_bit(input logic [7:0] a);
    case (a)
      A_CTRL:  return 5'b00001;
      A_CNT:   return 5'b00010;
      A_LOAD:  return 5'b00100;
      A_TRIG:  return 5'b01000;
      A_MATCH: return 5'b10000;
      default: return 5'b00000;
    endcase
  endfunction
endpackage

// File: rtl/gpt_count.sv
module gpt_count #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic         en_i,
  input  logic         ar_i,
  input  logic         pre_en_i,
  input  logic [2:0]   ptv_i,
  input  logic         ce_i,
  input  logic [W-1:0] load_i,
  input  logic [W-1:0] match_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         reload_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o,
  output logic         match_o
);
  localparam int PW = 8;

  logic [W-1:0]  cnt_q, nxt;
  logic [PW-1:0] psc_q, lim;
  logic          fire, adv;

  assign lim  = PW'((9'd2 << ptv_i) - 9'd1);
  assign fire = !pre_en_i || (psc_q == lim);
  assign adv  = en_i && tick_i && fire && !clr_i && !wr_i && !reload_i;
  assign ovf_o = adv && (cnt_q == '1);
  assign nxt  = ovf_o ? (ar_i ? load_i : '0) : cnt_q + 1'b1;
  assign match_o = adv && ce_i && (nxt == match_i);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) psc_q <= '0;
    else if (clr_i || !en_i || !pre_en_i) psc_q <= '0;
    else if (tick_i) psc_q <= (psc_q == lim) ? '0 : psc_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (wr_i) cnt_q <= wdata_i;
    else if (reload_i) cnt_q <= load_i;
    else if (adv) cnt_q <= nxt;
  end

  // R3
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !wr_i && !reload_i && !clr_i |=> $stable(cnt_q));
  // R6
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !ar_i |=> cnt_q == '0);
endmodule

// File: rtl/gpt_capture.sv
module gpt_capture #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         cap_i,
  input  logic [1:0]   edge_sel_i,
  input  logic         every2_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] cap_o,
  output logic         ev_o
);
  logic s1_q, s2_q, prev_q, par_q, hit;
  logic [W-1:0] cap_q;

  assign hit  = (edge_sel_i[0] && s2_q && !prev_q) || (edge_sel_i[1] && !s2_q && prev_q);
  assign ev_o = hit && (!every2_i || par_q);
  assign cap_o = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0; s2_q <= 1'b0; prev_q <= 1'b0;
    end else begin
      s1_q <= cap_i; s2_q <= s1_q; prev_q <= s2_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_q <= 1'b0; cap_q <= '0;
    end else if (clr_i) begin
      par_q <= 1'b0; cap_q <= '0;
    end else begin
      if (edge_sel_i == 2'b00) par_q <= 1'b0;
      else if (hit) par_q <= ~par_q;
      if (ev_o) cap_q <= cnt_i;
    end
  end

  // R9
  cap_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_sel_i == 2'b00 && !clr_i |=> $stable(cap_q));
endmodule

// File: rtl/gpt_out.sv
module gpt_out (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       ev_ovf_i,
  input  logic       ev_match_i,
  input  logic [1:0] trg_i,
  input  logic       tgl_i,
  input  logic       def_i,
  input  logic       gpo_i,
  output logic       pwm_o
);
  logic fire, tgl_q, pls_q;

  always_comb begin
    case (trg_i)
      2'b01:   fire = ev_ovf_i;
      2'b10:   fire = ev_ovf_i || ev_match_i;
      2'b11:   fire = ev_match_i;
      default: fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_q <= 1'b0; pls_q <= 1'b0;
    end else if (clr_i) begin
      tgl_q <= 1'b0; pls_q <= 1'b0;
    end else begin
      if (trg_i == 2'b00 || !tgl_i) tgl_q <= 1'b0;
      else if (fire) tgl_q <= ~tgl_q;
      pls_q <= fire && !tgl_i;
    end
  end

  assign pwm_o = gpo_i ? def_i : def_i ^ (tgl_i ? tgl_q : pls_q);
endmodule

// File: rtl/gpt_regs.sv
module gpt_regs
  import gpt_pkg::*;
#(
  parameter int W        = 32,
  parameter int SYNC_LAT = 2,
  parameter int RST_CYC  = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         rd_i,
  input  logic [7:0]   addr_i,
  input  logic [31:0]  wdata_i,
  output logic [31:0]  rdata_o,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cap_val_i,
  input  logic         ev_match_i,
  input  logic         ev_ovf_i,
  input  logic         ev_cap_i,
  output ctrl_t        ctrl_o,
  output logic [W-1:0] load_o,
  output logic [W-1:0] match_o,
  output logic         cnt_wr_o,
  output logic [W-1:0] cnt_wdata_o,
  output logic         reload_o,
  output logic         clr_o,
  output logic         irq_o
);
  localparam int LW  = $clog2(SYNC_LAT + 1);
  localparam int RCW = $clog2(RST_CYC + 1);

  ctrl_t          ctrl_q;
  logic [W-1:0]   load_q, match_q;
  logic [2:0]     ien_q, stat_q, w1c;
  logic           posted_q, pend_q, busy, done, srst_req, ifc_wr, timer_wr;
  logic [LW-1:0]  lat_q;
  logic [RCW-1:0] rst_cnt_q;
  logic [7:0]     stg_addr_q, commit_a;
  logic [31:0]    stg_data_q, commit_d;
  logic           commit_v;

  assign busy     = rst_cnt_q != '0;
  assign done     = !busy;
  assign ifc_wr   = wr_i && (addr_i == A_IFC);
  assign srst_req = ifc_wr && wdata_i[1];
  assign clr_o    = busy || srst_req;
  assign timer_wr = wr_i && !busy && is_tdom(addr_i);

  assign commit_v = posted_q ? (pend_q && lat_q == '0) : timer_wr;
  assign commit_a = posted_q ? stg_addr_q : addr_i;
  assign commit_d = posted_q ? stg_data_q : wdata_i;

  assign cnt_wr_o    = commit_v && !clr_o && (commit_a == A_CNT);
  assign reload_o    = commit_v && !clr_o && (commit_a == A_TRIG);
  assign cnt_wdata_o = commit_d[W-1:0];

  // posted-write staging and soft-reset sequencing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      posted_q <= 1'b0; pend_q <= 1'b0; lat_q <= '0;
      stg_addr_q <= '0; stg_data_q <= '0; rst_cnt_q <= '0;
    end else begin
      if (busy) rst_cnt_q <= rst_cnt_q - 1'b1;
      if (ifc_wr) begin
        posted_q <= wdata_i[2];
        pend_q   <= 1'b0;
        if (wdata_i[1]) rst_cnt_q <= RCW'(RST_CYC);
      end else if (busy) begin
        pend_q <= 1'b0;
      end else if (posted_q && timer_wr) begin
        pend_q     <= 1'b1;
        lat_q      <= LW'(SYNC_LAT - 1);
        stg_addr_q <= addr_i;
        stg_data_q <= wdata_i;
      end else if (pend_q) begin
        if (lat_q == '0) pend_q <= 1'b0;
        else lat_q <= lat_q - 1'b1;
      end
    end
  end

  assign w1c = (wr_i && addr_i == A_ISTAT) ? wdata_i[2:0] : 3'b000;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0; load_q <= '0; match_q <= '0; ien_q <= '0; stat_q <= '0;
    end else if (clr_o) begin
      ctrl_q <= '0; load_q <= '0; match_q <= '0; ien_q <= '0; stat_q <= '0;
    end else begin
      if (commit_v) begin
        case (commit_a)
          A_CTRL:  ctrl_q  <= ctrl_t'(commit_d & CTRL_MASK);
          A_LOAD:  load_q  <= commit_d[W-1:0];
          A_MATCH: match_q <= commit_d[W-1:0];
          default: ;
        endcase
      end
      if (ev_ovf_i && !ctrl_q.ar) ctrl_q.start <= 1'b0;
      if (wr_i && addr_i == A_IEN) ien_q <= wdata_i[2:0];
      stat_q <= (stat_q & ~w1c) | {ev_cap_i, ev_ovf_i, ev_match_i};
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (addr_i)
        A_SYSST: rdata_o = {31'b0, done};
        A_ISTAT: rdata_o = {29'b0, stat_q};
        A_IEN:   rdata_o = {29'b0, ien_q};
        A_CTRL:  rdata_o = ctrl_q;
        A_CNT:   rdata_o = 32'(cnt_i);
        A_LOAD:  rdata_o = 32'(load_q);
        A_PEND:  rdata_o = pend_q ? {27'b0, pend_bit(stg_addr_q)} : 32'b0;
        A_MATCH: rdata_o = 32'(match_q);
        A_CAPT:  rdata_o = 32'(cap_val_i);
        A_IFC:   rdata_o = {29'b0, posted_q, 2'b0};
        default: rdata_o = '0;
      endcase
    end
  end

  assign ctrl_o  = ctrl_q;
  assign load_o  = load_q;
  assign match_o = match_q;
  assign irq_o   = |(stat_q & ien_q);

  // R6
  ovf_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_ovf_i && !ctrl_q.ar |=> !ctrl_q.start);
  // R12
  srst_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |-> ctrl_q == '0);
  // R2
  pend_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(wr_i));
endmodule

// File: rtl/gpt_timer.sv
module gpt_timer
  import gpt_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int SYNC_LAT = 2,
  parameter int RST_CYC  = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_wr_i,
  input  logic        bus_rd_i,
  input  logic [7:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  input  logic        tick_i,
  input  logic        cap_i,
  output logic        pwm_o,
  output logic        irq_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] cnt, cap_val, load, match, cnt_wdata;
  logic             ev_match, ev_ovf, ev_cap, cnt_wr, reload, clr;

  gpt_regs #(.W(CNT_W), .SYNC_LAT(SYNC_LAT), .RST_CYC(RST_CYC)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(bus_wr_i), .rd_i(bus_rd_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .cnt_i(cnt), .cap_val_i(cap_val),
    .ev_match_i(ev_match), .ev_ovf_i(ev_ovf), .ev_cap_i(ev_cap),
    .ctrl_o(ctrl), .load_o(load), .match_o(match),
    .cnt_wr_o(cnt_wr), .cnt_wdata_o(cnt_wdata), .reload_o(reload),
    .clr_o(clr), .irq_o
  );

  gpt_count #(.W(CNT_W)) u_count (
    .clk_i, .rst_ni, .clr_i(clr), .tick_i,
    .en_i(ctrl.start), .ar_i(ctrl.ar), .pre_en_i(ctrl.pre_en), .ptv_i(ctrl.ptv),
    .ce_i(ctrl.cmp_en), .load_i(load), .match_i(match),
    .wr_i(cnt_wr), .wdata_i(cnt_wdata), .reload_i(reload),
    .cnt_o(cnt), .ovf_o(ev_ovf), .match_o(ev_match)
  );

  gpt_capture #(.W(CNT_W)) u_capture (
    .clk_i, .rst_ni, .clr_i(clr), .cap_i,
    .edge_sel_i(ctrl.edge_sel), .every2_i(ctrl.capt2),
    .cnt_i(cnt), .cap_o(cap_val), .ev_o(ev_cap)
  );

  gpt_out u_out (
    .clk_i, .rst_ni, .clr_i(clr),
    .ev_ovf_i(ev_ovf), .ev_match_i(ev_match),
    .trg_i(ctrl.trg), .tgl_i(ctrl.tgl), .def_i(ctrl.def_lvl), .gpo_i(ctrl.gpo),
    .pwm_o
  );
endmodule

// File: tb/gpt_timer_tb.sv
module gpt_timer_tb;
  localparam int CLK_PERIOD = 10;

  localparam logic [7:0] SYSST = 8'h14, ISTAT = 8'h18, IEN = 8'h1C, CTRL = 8'h24,
                         CNT = 8'h28, LOAD = 8'h2C, TRIG = 8'h30, PEND = 8'h34,
                         MATCH = 8'h38, CAPT = 8'h3C, IFC = 8'h40;

  typedef struct packed {
    logic       pre;
    logic [2:0] ptv;
    logic [7:0] n;
    logic [7:0] exp_cnt;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 3'd0, 8'd12, 8'd12},
    '{1'b1, 3'd0, 8'd12, 8'd6},
    '{1'b1, 3'd1, 8'd12, 8'd3},
    '{1'b1, 3'd2, 8'd20, 8'd2},
    '{1'b1, 3'd2, 8'd15, 8'd1},
    '{1'b1, 3'd3, 8'd40, 8'd2}
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        bus_wr_i = 1'b0, bus_rd_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0, bus_rdata_o;
  logic        tick_i = 1'b0, cap_i = 1'b0, pwm_o, irq_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  gpt_timer u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_rd_i = 1'b1;
    #1 d = bus_rdata_o;
    bus_rd_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    check(req, d, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk_i);
    tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd_chk("R1 ctrl", CTRL, 32'h0);
    rd_chk("R1 sysstat", SYSST, 32'h1);
    rd_chk("R1 pending", PEND, 32'h0);
    rd_chk("R1 ifctrl", IFC, 32'h0);
    rd_chk("R1 counter", CNT, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 pwm", {31'b0, pwm_o}, 32'h0);

    // R13 direct counter access; R2 non-posted leaves no pending
    bus_wr(CNT, 32'h1234_5678);
    rd_chk("R2 nonposted pending", PEND, 32'h0);
    rd_chk("R13 counter readback", CNT, 32'h1234_5678);

    // R6 overflow without auto-reload
    bus_wr(CTRL, 32'h1);
    bus_wr(CNT, 32'hFFFF_FFFE);
    ticks(2);
    rd_chk("R6 wrap to zero", CNT, 32'h0);
    rd_chk("R6 start cleared", CTRL, 32'h0);
    rd_chk("R6 overflow flag", ISTAT, 32'h2);
    bus_wr(ISTAT, 32'h7);
    ticks(5);
    rd_chk("R3 stopped holds", CNT, 32'h0);

    // R6 overflow with auto-reload, R3 continued counting
    bus_wr(LOAD, 32'h10);
    bus_wr(CTRL, 32'h3);
    bus_wr(CNT, 32'hFFFF_FFFF);
    ticks(1);
    rd_chk("R6 reload value", CNT, 32'h10);
    rd_chk("R6 start kept", CTRL, 32'h3);
    ticks(3);
    rd_chk("R3 counts per tick", CNT, 32'h13);

    // R5 trigger reload
    bus_wr(CTRL, 32'h0);
    bus_wr(LOAD, 32'h100);
    bus_wr(TRIG, 32'hDEAD);
    rd_chk("R5 trigger reload", CNT, 32'h100);
    rd_chk("R5 trigger reads zero", TRIG, 32'h0);

    // R7 match, R8 interrupt masking and clear
    bus_wr(ISTAT, 32'h7);
    bus_wr(IEN, 32'h1);
    bus_wr(MATCH, 32'h5);
    bus_wr(CNT, 32'h3);
    bus_wr(CTRL, 32'h41);
    check("R8 irq idle", {31'b0, irq_o}, 32'h0);
    ticks(1);
    rd_chk("R7 no match before", ISTAT, 32'h0);
    ticks(1);
    rd_chk("R7 match flag", ISTAT, 32'h1);
    check("R8 irq raised", {31'b0, irq_o}, 32'h1);
    bus_wr(ISTAT, 32'h1);
    check("R8 irq cleared", {31'b0, irq_o}, 32'h0);
    rd_chk("R8 w1c", ISTAT, 32'h0);
    bus_wr(IEN, 32'h0);
    bus_wr(CNT, 32'h4);
    ticks(1);
    rd_chk("R7 match again", ISTAT, 32'h1);
    check("R8 irq masked", {31'b0, irq_o}, 32'h0);
    bus_wr(ISTAT, 32'h7);
    bus_wr(CTRL, 32'h1);
    bus_wr(CNT, 32'h4);
    ticks(1);
    rd_chk("R7 compare disabled", ISTAT, 32'h0);
    bus_wr(CTRL, 32'h0);

    // R4 prescaler table (R3 for the undivided entry)
    foreach (VEC[i]) begin
      bus_wr(CTRL, 32'h0);
      bus_wr(CNT, 32'h0);
      bus_wr(CTRL, {26'b0, VEC[i].pre, VEC[i].ptv, 2'b01});
      ticks(int'(VEC[i].n));
      bus_rd(CNT, d);
      check($sformatf("R4 prescale vec %0d", i), d, {24'b0, VEC[i].exp_cnt});
    end
    bus_wr(CTRL, 32'h0);

    // R9 capture edges
    bus_wr(ISTAT, 32'h7);
    bus_wr(CTRL, 32'h100);
    bus_wr(CNT, 32'h77);
    @(negedge clk_i) cap_i = 1'b1;
    settle();
    rd_chk("R9 rising capture", CAPT, 32'h77);
    rd_chk("R9 capture flag", ISTAT, 32'h4);
    bus_wr(ISTAT, 32'h4);
    bus_wr(CNT, 32'h88);
    @(negedge clk_i) cap_i = 1'b0;
    settle();
    rd_chk("R9 falling ignored", CAPT, 32'h77);
    rd_chk("R9 no flag on falling", ISTAT, 32'h0);
    bus_wr(CTRL, 32'h300);
    @(negedge clk_i) cap_i = 1'b1;
    settle();
    rd_chk("R9 both edges", CAPT, 32'h88);
    bus_wr(CNT, 32'h99);
    bus_wr(CTRL, 32'h0);
    @(negedge clk_i) cap_i = 1'b0;
    settle();
    rd_chk("R9 capture off", CAPT, 32'h88);

    // R10 every second edge
    bus_wr(ISTAT, 32'h7);
    bus_wr(CTRL, 32'h2100);
    bus_wr(CNT, 32'hAA);
    @(negedge clk_i) cap_i = 1'b1;
    settle();
    rd_chk("R10 first edge skipped", CAPT, 32'h88);
    @(negedge clk_i) cap_i = 1'b0;
    settle();
    bus_wr(CNT, 32'hBB);
    @(negedge clk_i) cap_i = 1'b1;
    settle();
    rd_chk("R10 second edge captured", CAPT, 32'hBB);
    bus_wr(CTRL, 32'h0);

    // R11 waveform output: toggle on overflow
    bus_wr(LOAD, 32'hFFFF_FFFE);
    bus_wr(CNT, 32'hFFFF_FFFE);
    bus_wr(CTRL, 32'h1403);
    check("R11 toggle idle", {31'b0, pwm_o}, 32'h0);
    ticks(2);
    check("R11 toggle high", {31'b0, pwm_o}, 32'h1);
    ticks(2);
    check("R11 toggle low", {31'b0, pwm_o}, 32'h0);
    // pulse mode
    bus_wr(CTRL, 32'h0403);
    ticks(1);
    check("R11 pulse idle", {31'b0, pwm_o}, 32'h0);
    @(negedge clk_i) tick_i = 1'b1;
    @(negedge clk_i) tick_i = 1'b0;
    check("R11 pulse active", {31'b0, pwm_o}, 32'h1);
    @(negedge clk_i);
    check("R11 pulse one cycle", {31'b0, pwm_o}, 32'h0);
    // idle level high
    bus_wr(CTRL, 32'h0483);
    check("R11 idle high", {31'b0, pwm_o}, 32'h1);
    ticks(1);
    @(negedge clk_i) tick_i = 1'b1;
    @(negedge clk_i) tick_i = 1'b0;
    check("R11 inverted pulse", {31'b0, pwm_o}, 32'h0);
    @(negedge clk_i);
    check("R11 back to idle", {31'b0, pwm_o}, 32'h1);
    // plain output
    bus_wr(CTRL, 32'h5483);
    ticks(4);
    check("R11 gpo follows level", {31'b0, pwm_o}, 32'h1);
    bus_wr(CTRL, 32'h0);

    // R12 soft reset
    bus_wr(LOAD, 32'h42);
    bus_wr(IEN, 32'h7);
    bus_wr(CTRL, 32'h3);
    bus_wr(IFC, 32'h6);
    rd_chk("R12 reset busy", SYSST, 32'h0);
    begin
      int k;
      k = 0;
      d = 32'h0;
      while (k < 20 && d != 32'h1) begin
        bus_rd(SYSST, d);
        k++;
      end
      check("R12 reset done", d, 32'h1);
    end
    rd_chk("R12 ctrl cleared", CTRL, 32'h0);
    rd_chk("R12 load cleared", LOAD, 32'h0);
    rd_chk("R12 ien cleared", IEN, 32'h0);
    rd_chk("R12 counter cleared", CNT, 32'h0);
    rd_chk("R12 capture cleared", CAPT, 32'h0);
    rd_chk("R12 posted bit", IFC, 32'h4);

    // R2 posted write
    bus_wr(LOAD, 32'h55);
    rd_chk("R2 pending load bit", PEND, 32'h4);
    rd_chk("R2 committed", LOAD, 32'h55);
    rd_chk("R2 pending clear", PEND, 32'h0);

    finish_run();
  end
endmodule